// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block moves data words from a producer running on one clock to a consumer running on a second clock. The two clocks have no fixed phase or frequency relation. Words are stored in a dual-port register array. The producer writes at a location set by a write pointer, and the consumer reads at a location set by a read pointer. Each pointer is one bit wider than the array address. The extra bit tells a full array apart from an empty one when the addresses match.

Each pointer is turned into Gray code before it crosses to the other clock. Two Gray values for neighbouring counts differ in one bit only, so a value sampled while it is changing resolves to either the old count or the new count. The receiving clock passes the crossed value through a chain of at least two flip-flops before any logic uses it. The full flag, empty flag and fill level are kept separately on each side. Each side computes them in its own clock domain from its own pointer and the synchronized copy of the other pointer, and every one of them is registered.

Because the synchronized copy of the far pointer is always behind the true value, each side is conservative. The write side may still report full after a read has freed a slot, and the read side may still report empty after a word has arrived. Neither side ever reports room or data that does not exist. Reading works as a registered request: the word appears on the read data port after the read-clock edge that accepts the request.

Top module: `afifo_dual_clock`

## Requirements
- R1: While a side's active-low reset is low, and after it is released with no traffic, that side shows empty = 1, full = 0 and level = 0. `rd_data` resets to 0.
- R2: Words leave the read port in exactly the order in which the write port accepted them, with no loss and no duplication, under any mix of write and read gaps.
- R3: A write request made while `wr_full` is 1 is ignored. The word is never delivered, and `wr_level` stays at DEPTH.
- R4: A read request made while `rd_empty` is 1 is ignored. `rd_data` keeps its value, and `rd_level` stays 0.
- R5: `wr_full` rises on the write edge that stores the DEPTH-th unread word, so the very next write request is refused. `wr_full` is only 1 when `wr_level` equals DEPTH, and full and empty are never both 1 on one side.
- R6: Each level output is a registered count from 0 to DEPTH. When no traffic has been applied for more than the synchronizer depth plus two cycles of that side's clock, both levels equal the true number of stored words.
- R7: An accepted read places the oldest stored word on `rd_data` right after that read-clock edge. `rd_data` holds this word until the next accepted read.
- R8: Once all words have been read and traffic stops, the write side returns to empty = 1, full = 0 and level = 0 within a few write-clock cycles.
- R9: The flags are safe. Whenever `wr_full` is 0, fewer than DEPTH words are truly stored. Whenever `rd_empty` is 0, at least one word is truly stored. Each Gray pointer changes by at most one bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| wr_full | output | 1 | No free slot, seen from the write clock |
| wr_empty | output | 1 | No stored word, seen from the write clock |
| wr_level | output | AW+1 | Stored word count, seen from the write clock |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Last word read |
| rd_full | output | 1 | No free slot, seen from the read clock |
| rd_empty | output | 1 | No stored word, seen from the read clock |
| rd_level | output | AW+1 | Stored word count, seen from the read clock |

## Verification
The bench fills the buffer with a burst longer than the depth. A block whose full flag rose one edge late would take one extra word and overwrite the oldest unread entry, and that corruption shows up as a data mismatch when the buffer is drained. The bench then reads once more while the buffer is empty. A block without underflow protection would step its read pointer past the write pointer, which changes `rd_data` and wraps the level. A streaming phase with irregular gaps, running on two unrelated clock periods, checks the order against a queue model. On every cycle of both clocks the bench also checks that neither flag claims room or data the queue model does not have. A block that compared binary pointers, or that inverted the wrong pointer bits in the full test, would fail these checks.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;

    // binary to Gray: top bit kept, each lower bit xor-ed with the bit above it
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary: each bit is the xor of all Gray bits at or above it
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
module afifo_mem #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end
endmodule

// File: rtl/afifo_wr_ctrl.sv
`timescale 1ns/1ps
module afifo_wr_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] rgray_sync,
    output logic          accept,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          empty,
    output logic [PW-1:0] level
);
    localparam logic [PW-1:0] TOP2 = {2'b11, {(PW-2){1'b0}}};

    logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s;

    assign accept   = push && !full;
    assign wbin_nx  = wbin + PW'(accept);
    assign wgray_nx = PW'(bin2gray(32'(wbin_nx)));
    assign rbin_s   = PW'(gray2bin(32'(rgray_sync)));
    assign waddr    = wbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
            level <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
            full  <= (wgray_nx == (rgray_sync ^ TOP2));
            empty <= (wgray_nx == rgray_sync);
            level <= wbin_nx - rbin_s;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> $stable(wgray));
    a_r5_full_means_depth: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == PW'(DEPTH)));
    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
    a_r9_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/afifo_rd_ctrl.sv
`timescale 1ns/1ps
module afifo_rd_ctrl
    import afifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic [PW-1:0] wgray_sync,
    output logic          accept,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic          full,
    output logic          empty,
    output logic [PW-1:0] level
);
    localparam logic [PW-1:0] TOP2 = {2'b11, {(PW-2){1'b0}}};

    logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s;

    assign accept   = pop && !empty;
    assign rbin_nx  = rbin + PW'(accept);
    assign rgray_nx = PW'(bin2gray(32'(rbin_nx)));
    assign wbin_s   = PW'(gray2bin(32'(wgray_sync)));
    assign raddr    = rbin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
            level <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rgray_nx;
            full  <= (rgray_nx == (wgray_sync ^ TOP2));
            empty <= (rgray_nx == wgray_sync);
            level <= wbin_s - rbin_nx;
        end
    end

    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(rgray));
    a_r9_empty_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (level == '0));
    a_r5_rd_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r6_rd_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
    a_r9_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/afifo_dual_clock.sv
`timescale 1ns/1ps
module afifo_dual_clock #(
    parameter int DW          = 8,
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(DEPTH),
    localparam int PW         = AW + 1
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full,
    output logic          wr_empty,
    output logic [PW-1:0] wr_level,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_full,
    output logic          rd_empty,
    output logic [PW-1:0] rd_level
);
    initial begin
        assert ((DEPTH >= 2) && ((DEPTH & (DEPTH - 1)) == 0))
            else $error("DEPTH must be a power of two");
        assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2");
    end

    logic          w_acc, r_acc;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

    afifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .push(wr_en), .rgray_sync(rgray_s),
        .accept(w_acc), .waddr(waddr), .wgray(wgray),
        .full(wr_full), .empty(wr_empty), .level(wr_level)
    );

    afifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .pop(rd_en), .wgray_sync(wgray_s),
        .accept(r_acc), .raddr(raddr), .rgray(rgray),
        .full(rd_full), .empty(rd_empty), .level(rd_level)
    );

    afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d_async(rgray), .q_sync(rgray_s)
    );

    afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d_async(wgray), .q_sync(wgray_s)
    );

    afifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .wclk(wr_clk), .we(w_acc), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst_n(rd_rst_n), .re(r_acc), .raddr(raddr),
        .rdata(rd_data)
    );
endmodule

// File: tb/test_afifo_dual_clock.sv
`timescale 1ns/1ps
module test_afifo_dual_clock;
    localparam int DW    = 8;
    localparam int DEPTH = 8;
    localparam int PW    = $clog2(DEPTH) + 1;
    localparam int NSTREAM = 60;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_rst_n = 0, rd_rst_n = 0;
    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full, wr_empty, rd_full, rd_empty;
    logic [PW-1:0] wr_level, rd_level;
    logic [DW-1:0] rd_data;

    int checks = 0, failures = 0;
    bit live = 0, done = 0;
    logic [DW-1:0] q [$];

    always #2 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    afifo_dual_clock #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) i_afifo_dual_clock (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_empty(wr_empty), .wr_level(wr_level),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_full(rd_full), .rd_empty(rd_empty), .rd_level(rd_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: one write attempt; accepted words go to the scoreboard queue
    task automatic put(input logic [DW-1:0] d, output bit took);
        @(negedge wr_clk);
        wr_en = 1; wr_data = d; took = !wr_full;
        @(posedge wr_clk); #1;
        wr_en = 0;
        if (took) q.push_back(d);
    endtask

    // monitor side: one read attempt; accepted words compared with the queue head
    task automatic get(output bit took);
        logic [DW-1:0] exp;
        @(negedge rd_clk);
        rd_en = 1; took = !rd_empty;
        @(posedge rd_clk); #1;
        rd_en = 0;
        if (took) begin
            if (q.size() == 0) begin
                chk("R2 read with empty model", 32'(rd_data), 32'hFFFF_FFFF);
            end else begin
                exp = q.pop_front();
                chk("R2/R7 read order", 32'(rd_data), 32'(exp));
            end
        end
    endtask

    // R9: flags never claim room or data that is not there
    always @(negedge wr_clk) if (live && !wr_full) chk("R9 wr_full safe", 32'(q.size() < DEPTH), 1);
    always @(negedge rd_clk) if (live && !rd_empty) chk("R9 rd_empty safe", 32'(q.size() > 0), 1);

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        bit took;
        int acc;
        logic [DW-1:0] held;

        // R1 during and after reset
        repeat (3) @(posedge rd_clk);
        @(negedge wr_clk);
        chk("R1 wr_empty in reset", 32'(wr_empty), 1);
        chk("R1 wr_full in reset", 32'(wr_full), 0);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk);
        chk("R1 rd_empty", 32'(rd_empty), 1);
        chk("R1 rd_full", 32'(rd_full), 0);
        chk("R1 rd_level", 32'(rd_level), 0);
        chk("R1 rd_data", 32'(rd_data), 0);
        chk("R1 wr_level", 32'(wr_level), 0);
        chk("R1 wr_empty", 32'(wr_empty), 1);
        live = 1;

        // R3/R5: burst past capacity
        acc = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            put(8'(8'hA0 + i), took);
            if (took) acc++;
            if (i == DEPTH - 1) chk("R5 full right after DEPTH-th write", 32'(wr_full), 1);
        end
        chk("R3 accepted count", 32'(acc), DEPTH);
        chk("R3 wr_level held at DEPTH", 32'(wr_level), DEPTH);
        chk("R5 wr_empty low when full", 32'(wr_empty), 0);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
        chk("R6 rd_level settles", 32'(rd_level), DEPTH);
        chk("R5 rd_full settles", 32'(rd_full), 1);

        // drain, then one read on empty
        for (int i = 0; i < DEPTH; i++) begin
            get(took);
            chk("R2 drain read accepted", 32'(took), 1);
        end
        chk("R7 last word on rd_data", 32'(rd_data), 32'(8'hA0 + DEPTH - 1));
        chk("R4 rd_empty after drain", 32'(rd_empty), 1);
        held = rd_data;
        get(took);
        chk("R4 read refused while empty", 32'(took), 0);
        chk("R4 rd_data unchanged", 32'(rd_data), 32'(held));
        chk("R4 rd_level stays 0", 32'(rd_level), 0);
        repeat (8) @(posedge wr_clk);
        @(negedge wr_clk);
        chk("R8 wr_empty after drain", 32'(wr_empty), 1);
        chk("R8 wr_full after drain", 32'(wr_full), 0);
        chk("R8 wr_level after drain", 32'(wr_level), 0);

        // R2: streaming with irregular gaps on both sides
        fork
            begin
                for (int n = 0; n < NSTREAM; n++) begin
                    do put(8'(n * 37 + 5), took); while (!took);
                    repeat ($urandom % 3) @(posedge wr_clk);
                end
            end
            begin
                int got = 0;
                while (got < NSTREAM) begin
                    get(took);
                    if (took) got++;
                    repeat ($urandom % 2) @(posedge rd_clk);
                end
            end
        join
        chk("R2 model drained", 32'(q.size()), 0);
        repeat (8) @(posedge rd_clk);
        @(negedge wr_clk);
        chk("R6 wr_level quiescent", 32'(wr_level), 0);
        chk("R6 rd_level quiescent", 32'(rd_level), 0);

        live = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule